// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting channel of an interval timer. Software sets it up with one control byte and then writes an initial count one or two bytes at a time. From then on the channel counts on every system clock on which the count-tick enable is high. It drives a single output whose waveform depends on the selected mode. There are six modes: a terminal-count flag, a gate-triggered one-shot, a periodic one-tick pulse, a square wave, and two single strobes, one started by software and one started by the gate. Counting is either plain binary or four-digit decimal.

The gate input has a different meaning in each mode. In some modes it is a level that pauses counting. In others its rising edge starts the count or starts it again. All activity is synchronous to `clk`. A count tick is a `clk` edge on which `countTick` is high. Every cycle count given below assumes that `countTick` is high on every cycle.

Top module: `pit_channel`

## Requirements
- R1: After reset `outSig` is low, and count-byte writes have no effect until a control byte with a nonzero load format has been accepted.
- R2: A control byte holds the decimal-count select in bit 0, the mode in bits 3:1 and the load format in bits 5:4. The load formats are: 01 = low byte only (high byte becomes zero), 10 = high byte only (low byte becomes zero), 11 = low byte then high byte. A control byte with format 00 is ignored entirely, and bits 7:6 are ignored.
- R3: Mode 0: `outSig` goes low on the control-byte write and again on every completed count write. It rises on the (N+1)-th count tick after the edge that completes the count, and then stays high. A two-byte count does nothing until its second byte arrives.
- R4: Mode 0: while `gate` is low the count holds and `outSig` does not change. Counting resumes from the held value when `gate` returns high.
- R5: An initial count of 0 means 65536 in binary and 10000 in decimal.
- R6: With bit 0 set, the count bytes are read as four decimal digits, so a written 0x12 lasts 12 ticks.
- R7: Mode 1: `outSig` is high after the control byte. A rising edge on `gate` drives it low from the tick on which the edge is seen, for N ticks.
- R8: Mode 1: a count written during an active pulse does not change that pulse. The new count is used from the next rising edge of `gate`.
- R9: Mode 2: the period is N ticks, and `outSig` is low for exactly one tick at the end of each period. While `gate` is low, `outSig` is forced high and counting stops. A rising edge of `gate` restarts a full period.
- R10: Mode 3: `outSig` is high for ceil(N/2) ticks and then low for floor(N/2) ticks, and this repeats. `gate` acts as it does in mode 2.
- R11: Mode codes 6 and 7 behave exactly like modes 2 and 3.
- R12: Mode 4: `outSig` is high after the control byte. It goes low for one tick, N+1 ticks after the edge that completes the count, and is not repeated.
- R13: Mode 5: `outSig` stays high until a rising edge of `gate`. It then goes low for one tick, N ticks after the tick on which the edge was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 1 = the write is a control byte, 0 = the write is a count byte |
| wrData | input | 8 | Write data |
| countTick | input | 1 | Count clock enable; each high cycle is one count tick |
| gate | input | 1 | Gate: a level enable or an edge trigger, depending on the mode |
| outSig | output | 1 | Channel output |

## Verification
The bench builds the channel with the default 16-bit count width. This width lets the zero-count cases run through the full 65536-tick and 10000-tick terminal counts inside the run. Small counts, odd and even, keep the periodic modes short enough that several whole periods can be compared tick by tick. With these counts the bench can check the uneven high and low halves of the square wave, the aliased mode codes, the pause under gate, and the retrigger behaviour against a cycle-exact expected waveform.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  typedef enum logic [2:0] {
    MODE_TC_FLAG   = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } pitMode_t;

  typedef enum logic [1:0] {
    LOAD_NONE = 2'b00,
    LOAD_LOW  = 2'b01,
    LOAD_HIGH = 2'b10,
    LOAD_BOTH = 2'b11
  } loadFmt_t;

  // Strobes from the control to the count datapath
  typedef struct packed {
    logic wrLo;    // take wrData into low count byte
    logic wrHi;    // take wrData into high count byte
    logic clrLo;   // zero low count byte
    logic clrHi;   // zero high count byte
    logic ldFull;  // counter <= full effective count
    logic ldHigh;  // counter <= high half of square period
    logic ldLow;   // counter <= low half of square period
    logic dec;     // counter <= counter - 1
  } dpStrobe_t;

  // Codes with bit 1 set fold onto 2 and 3
  function automatic pitMode_t aliasMode(input logic [2:0] code);
    logic [2:0] folded;
    folded = code[1] ? {1'b0, code[1:0]} : code;
    return pitMode_t'(folded);
  endfunction

  function automatic int unsigned pow10(input int unsigned e);
    int unsigned acc;
    acc = 1;
    for (int unsigned i = 0; i < e; i++) acc = acc * 10;
    return acc;
  endfunction

endpackage

// File: rtl/pit_count_path.sv
`timescale 1ns/1ps
module pit_count_path
  import pit_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       stb,
  input  logic [7:0]      wrData,
  input  logic            bcdMode,
  output logic            atOne,
  output logic            atTwo
);
  localparam int DIGITS = COUNT_W / 4;
  localparam int CNT_W  = COUNT_W + 1;
  localparam int HI_W   = COUNT_W - 8;
  localparam logic [CNT_W-1:0] BIN_FULL = {1'b1, {COUNT_W{1'b0}}};
  localparam logic [CNT_W-1:0] BCD_FULL = CNT_W'(pow10(DIGITS));

  logic [COUNT_W-1:0] countReg;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   digitTerm [DIGITS];
  logic [CNT_W-1:0]   bcdSum;
  logic [CNT_W-1:0]   effN;
  logic [CNT_W-1:0]   halfHigh;
  logic [CNT_W-1:0]   halfLow;

  // Programmed count bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
    end else begin
      if (stb.wrLo)       countReg[7:0] <= wrData;
      else if (stb.clrLo) countReg[7:0] <= '0;
      if (stb.wrHi)       countReg[COUNT_W-1:8] <= HI_W'(wrData);
      else if (stb.clrHi) countReg[COUNT_W-1:8] <= '0;
    end
  end

  // Decimal digits weighted into a binary value
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    localparam logic [CNT_W-1:0] WEIGHT = CNT_W'(pow10(d));
    assign digitTerm[d] = CNT_W'(countReg[4*d +: 4]) * WEIGHT;
  end

  always_comb begin
    bcdSum = '0;
    for (int d = 0; d < DIGITS; d++) bcdSum = bcdSum + digitTerm[d];
  end

  always_comb begin
    if (countReg == '0) effN = bcdMode ? BCD_FULL : BIN_FULL;
    else                effN = bcdMode ? bcdSum : {1'b0, countReg};
    halfHigh = (effN + CNT_W'(1)) >> 1;
    halfLow  = effN >> 1;
  end

  // Working down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (stb.ldFull) cnt <= effN;
    else if (stb.ldHigh) cnt <= halfHigh;
    else if (stb.ldLow)  cnt <= halfLow;
    else if (stb.dec)    cnt <= cnt - CNT_W'(1);
  end

  assign atOne = (cnt == CNT_W'(1));
  assign atTwo = (cnt == CNT_W'(2));

endmodule

// File: rtl/pit_ctrl.sv
`timescale 1ns/1ps
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [5:0] ctrlBits,
  input  logic       countTick,
  input  logic       gate,
  input  logic       atOne,
  input  logic       atTwo,
  output dpStrobe_t  stb,
  output logic       bcdMode,
  output pitMode_t   modeEff,
  output logic       outSig
);
  logic [2:0] modeQ, modeN;
  logic       bcdQ, bcdN;
  loadFmt_t   fmtQ, fmtN;
  logic       msbNextQ, msbNextN;
  logic       armedQ, armedN;
  logic       newCountQ, newCountN;
  logic       activeQ, activeN;
  logic       trigQ, trigN;
  logic       outQ, outN;
  logic       gateQ;
  logic       gateRise;
  logic       trigNow;
  logic       countDone;

  assign modeEff = aliasMode(modeQ);
  assign bcdMode = bcdQ;
  assign outSig  = outQ;

  always_comb begin
    stb       = '0;
    modeN     = modeQ;
    bcdN      = bcdQ;
    fmtN      = fmtQ;
    msbNextN  = msbNextQ;
    armedN    = armedQ;
    newCountN = newCountQ;
    activeN   = activeQ;
    trigN     = trigQ;
    outN      = outQ;
    countDone = 1'b0;
    gateRise  = gate && !gateQ;
    trigNow   = trigQ || (armedQ && gateRise);
    if (armedQ && gateRise) trigN = 1'b1;

    // Count-tick behaviour, per mode
    if (countTick && armedQ) begin
      case (modeEff)
        MODE_TC_FLAG, MODE_SW_STROBE: begin
          if (modeEff == MODE_SW_STROBE && !outQ) outN = 1'b1;
          if (newCountQ) begin
            stb.ldFull = 1'b1;
            newCountN  = 1'b0;
            activeN    = 1'b1;
          end else if (activeQ && gate) begin
            stb.dec = 1'b1;
            if (atOne) begin
              activeN = 1'b0;
              outN    = (modeEff == MODE_TC_FLAG);
            end
          end
        end
        MODE_ONESHOT, MODE_HW_STROBE: begin
          if (modeEff == MODE_HW_STROBE && !outQ) outN = 1'b1;
          if (trigNow) begin
            stb.ldFull = 1'b1;
            trigN      = 1'b0;
            activeN    = 1'b1;
            if (modeEff == MODE_ONESHOT) outN = 1'b0;
          end else if (activeQ) begin
            stb.dec = 1'b1;
            if (atOne) begin
              activeN = 1'b0;
              outN    = (modeEff == MODE_ONESHOT);
            end
          end
        end
        MODE_RATE: begin
          if (!gate) begin
            outN = 1'b1;
          end else if (trigNow || !activeQ) begin
            stb.ldFull = 1'b1;
            trigN      = 1'b0;
            newCountN  = 1'b0;
            activeN    = 1'b1;
            outN       = 1'b1;
          end else if (atOne) begin
            stb.ldFull = 1'b1;
            outN       = 1'b1;
          end else begin
            stb.dec = 1'b1;
            outN    = !atTwo;
          end
        end
        MODE_SQUARE: begin
          if (!gate) begin
            outN = 1'b1;
          end else if (trigNow || !activeQ) begin
            stb.ldHigh = 1'b1;
            trigN      = 1'b0;
            newCountN  = 1'b0;
            activeN    = 1'b1;
            outN       = 1'b1;
          end else if (atOne) begin
            if (outQ) begin
              stb.ldLow = 1'b1;
              outN      = 1'b0;
            end else begin
              stb.ldHigh = 1'b1;
              outN       = 1'b1;
            end
          end else begin
            stb.dec = 1'b1;
          end
        end
        default: ;
      endcase
    end

    // Register writes take precedence over the tick result
    if (wrEn && wrSel) begin
      if (ctrlBits[5:4] != 2'b00) begin
        modeN     = ctrlBits[3:1];
        bcdN      = ctrlBits[0];
        fmtN      = loadFmt_t'(ctrlBits[5:4]);
        msbNextN  = 1'b0;
        armedN    = 1'b0;
        newCountN = 1'b0;
        activeN   = 1'b0;
        trigN     = 1'b0;
        outN      = (aliasMode(ctrlBits[3:1]) != MODE_TC_FLAG);
      end
    end else if (wrEn && fmtQ != LOAD_NONE) begin
      case (fmtQ)
        LOAD_LOW: begin
          stb.wrLo  = 1'b1;
          stb.clrHi = 1'b1;
          countDone = 1'b1;
        end
        LOAD_HIGH: begin
          stb.wrHi  = 1'b1;
          stb.clrLo = 1'b1;
          countDone = 1'b1;
        end
        LOAD_BOTH: begin
          if (!msbNextQ) begin
            stb.wrLo = 1'b1;
            msbNextN = 1'b1;
          end else begin
            stb.wrHi  = 1'b1;
            msbNextN  = 1'b0;
            countDone = 1'b1;
          end
        end
        default: ;
      endcase
      if (countDone) begin
        armedN    = 1'b1;
        newCountN = 1'b1;
        if (modeEff == MODE_TC_FLAG) begin
          outN    = 1'b0;
          activeN = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= 3'd0;
      bcdQ      <= 1'b0;
      fmtQ      <= LOAD_NONE;
      msbNextQ  <= 1'b0;
      armedQ    <= 1'b0;
      newCountQ <= 1'b0;
      activeQ   <= 1'b0;
      trigQ     <= 1'b0;
      outQ      <= 1'b0;
      gateQ     <= 1'b0;
    end else begin
      modeQ     <= modeN;
      bcdQ      <= bcdN;
      fmtQ      <= fmtN;
      msbNextQ  <= msbNextN;
      armedQ    <= armedN;
      newCountQ <= newCountN;
      activeQ   <= activeN;
      trigQ     <= trigN;
      outQ      <= outN;
      gateQ     <= gate;
    end
  end

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       countTick,
  input  logic       gate,
  output logic       outSig
);
  dpStrobe_t stb;
  logic      atOne;
  logic      atTwo;
  logic      bcdMode;
  pitMode_t  modeEff;

  pit_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .ctrlBits  (wrData[5:0]),
    .countTick (countTick),
    .gate      (gate),
    .atOne     (atOne),
    .atTwo     (atTwo),
    .stb       (stb),
    .bcdMode   (bcdMode),
    .modeEff   (modeEff),
    .outSig    (outSig)
  );

  pit_count_path #(.COUNT_W(COUNT_W)) i_path (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .bcdMode (bcdMode),
    .atOne   (atOne),
    .atTwo   (atTwo)
  );

endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk
  import pit_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrSel,
  input logic [4:0] cwBits,
  input logic       countTick,
  input logic       gate,
  input logic       outSig,
  input pitMode_t   modeEff
);
  AST_TCFLAG_CTRL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && cwBits[4:3] != 2'b00 && cwBits[2:0] == 3'd0) |=> !outSig); // R3

  AST_TCFLAG_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeEff == MODE_TC_FLAG && !gate && !wrEn) |=> $stable(outSig)); // R4

  AST_RATE_ONE_TICK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (modeEff == MODE_RATE && !outSig && countTick && !wrEn) |=> outSig); // R9

  AST_PERIODIC_GATE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((modeEff == MODE_RATE || modeEff == MODE_SQUARE) && !gate && countTick && !wrEn) |=> outSig); // R10

  AST_SW_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (modeEff == MODE_SW_STROBE && !outSig && countTick && !wrEn) |=> outSig); // R12

endmodule

bind pit_channel pit_channel_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .cwBits    (wrData[5:1]),
  .countTick (countTick),
  .gate      (gate),
  .outSig    (outSig),
  .modeEff   (modeEff)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic       wrSel;
  logic [7:0] wrData;
  logic       countTick;
  logic       gate;
  logic       outSig;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  pit_channel i_pit_channel (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .countTick (countTick),
    .gate      (gate),
    .outSig    (outSig)
  );

  task automatic check(input string req, input string what, input logic exp);
    nChecks++;
    if (outSig !== exp) begin
      nFails++;
      $display("FAIL %s %s: outSig got %0b expected %0b", req, what, outSig, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    wrEn = 1'b1; wrSel = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  task automatic wrCount(input logic [7:0] v);
    wrEn = 1'b1; wrSel = 1'b0; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // Compare the periodic waveform: high iff (k-1) mod period < highLen
  task automatic comparePattern(input string req, input int period, input int highLen,
                                input int cycles, input int ignoreAt);
    for (int k = 1; k <= cycles; k++) begin
      if (k == ignoreAt) wrCtrl(8'h00);
      else               waitN(1);
      check(req, $sformatf("tick %0d", k), ((k - 1) % period) < highLen);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0; countTick = 1'b1; gate = 1'b1;
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    check("R1", "after reset", 1'b0);
    wrCount(8'h03);
    waitN(8);
    check("R1", "count write before control", 1'b0);
    wrCtrl(8'h04);   // mode 2 code with load format 00
    waitN(3);
    check("R2", "format 00 control ignored", 1'b0);
  endtask

  task automatic testTcFlag();
    gate = 1'b1;
    wrCtrl(8'h30);
    check("R3", "low after control", 1'b0);
    wrCount(8'h05);
    waitN(3);
    check("R3", "one of two bytes written", 1'b0);
    wrCount(8'h00);
    waitN(5);
    check("R3", "before terminal", 1'b0);
    waitN(1);
    check("R3", "at terminal", 1'b1);
    waitN(20);
    check("R3", "stays high", 1'b1);
  endtask

  task automatic testTcGate();
    gate = 1'b1;
    wrCtrl(8'h10);
    wrCount(8'h06);
    waitN(3);
    gate = 1'b0;
    waitN(10);
    check("R4", "paused by gate", 1'b0);
    gate = 1'b1;
    waitN(3);
    check("R4", "resumed, not done", 1'b0);
    waitN(1);
    check("R4", "resumed, terminal", 1'b1);
  endtask

  task automatic testFormatsAndBcd();
    gate = 1'b1;
    wrCtrl(8'h11);
    wrCount(8'h12);
    waitN(12);
    check("R6", "decimal 12 before end", 1'b0);
    waitN(1);
    check("R6", "decimal 12 at end", 1'b1);
    wrCtrl(8'h20);
    wrCount(8'h01);
    waitN(256);
    check("R2", "high-byte-only 256 before end", 1'b0);
    waitN(1);
    check("R2", "high-byte-only 256 at end", 1'b1);
  endtask

  task automatic testZeroCount();
    gate = 1'b1;
    wrCtrl(8'h31);
    wrCount(8'h00);
    wrCount(8'h00);
    waitN(10000);
    check("R5", "decimal zero before end", 1'b0);
    waitN(1);
    check("R5", "decimal zero at end", 1'b1);
    wrCtrl(8'h30);
    wrCount(8'h00);
    wrCount(8'h00);
    waitN(65536);
    check("R5", "binary zero before end", 1'b0);
    waitN(1);
    check("R5", "binary zero at end", 1'b1);
  endtask

  task automatic testOneShot();
    gate = 1'b0;
    wrCtrl(8'h12);
    check("R7", "high after control", 1'b1);
    wrCount(8'h04);
    waitN(5);
    check("R7", "no trigger yet", 1'b1);
    gate = 1'b1;
    waitN(1);
    check("R7", "pulse start", 1'b0);
    waitN(3);
    check("R7", "pulse last tick", 1'b0);
    waitN(1);
    check("R7", "pulse end", 1'b1);
    gate = 1'b0;
    waitN(2);
    gate = 1'b1;
    waitN(1);
    check("R8", "second pulse start", 1'b0);
    gate = 1'b0;
    wrCount(8'h0A);
    waitN(2);
    check("R8", "pulse keeps old length", 1'b0);
    waitN(1);
    check("R8", "old length ends pulse", 1'b1);
    gate = 1'b1;
    waitN(1);
    check("R8", "new count pulse start", 1'b0);
    waitN(9);
    check("R8", "new count pulse last tick", 1'b0);
    waitN(1);
    check("R8", "new count pulse end", 1'b1);
  endtask

  task automatic testRate();
    gate = 1'b1;
    wrCtrl(8'h14);
    wrCount(8'h04);
    comparePattern("R9", 4, 3, 12, 6);   // format-00 control at tick 6 ignored (R2)
    gate = 1'b0;
    waitN(1);
    check("R9", "gate low forces high", 1'b1);
    waitN(5);
    check("R9", "gate low holds high", 1'b1);
    gate = 1'b1;
    comparePattern("R9", 4, 3, 8, 0);
    wrCtrl(8'h1C);
    wrCount(8'h03);
    comparePattern("R11", 3, 2, 9, 0);
  endtask

  task automatic testSquare();
    gate = 1'b1;
    wrCtrl(8'h16);
    wrCount(8'h05);
    comparePattern("R10", 5, 3, 15, 0);
    wrCtrl(8'h1E);
    wrCount(8'h06);
    comparePattern("R11", 6, 3, 12, 0);
    wrCtrl(8'h17);
    wrCount(8'h10);
    comparePattern("R6", 10, 5, 20, 0);
  endtask

  task automatic testStrobes();
    gate = 1'b1;
    wrCtrl(8'h18);
    check("R12", "high after control", 1'b1);
    wrCount(8'h03);
    waitN(3);
    check("R12", "before strobe", 1'b1);
    waitN(1);
    check("R12", "strobe", 1'b0);
    waitN(1);
    check("R12", "after strobe", 1'b1);
    waitN(10);
    check("R12", "no repeat", 1'b1);
    gate = 1'b0;
    wrCtrl(8'h1A);
    wrCount(8'h03);
    waitN(5);
    check("R13", "no trigger yet", 1'b1);
    gate = 1'b1;
    waitN(3);
    check("R13", "before strobe", 1'b1);
    waitN(1);
    check("R13", "strobe", 1'b0);
    waitN(1);
    check("R13", "after strobe", 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testTcFlag();
    testTcGate();
    testFormatsAndBcd();
    testOneShot();
    testRate();
    testSquare();
    testStrobes();
    testZeroCount();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule